// File: doc/BRIEF.md
# Auto Power-On Button Sequencer

This controller makes sure that a host computer comes up whenever supply power returns, by pressing the host's power button on the host's behalf. After reset it runs a fixed retry loop. It waits a settling period and then looks at a filtered "host is running" status input. If the host is still off, it holds the button for a short pulse, lets go, and starts the wait again.

Once the status input confirms that the host is running, the controller drops into a terminal idle state and keeps the button released until its own next reset. This lockout allows an operator to shut the host down later without the controller pressing the button again.

The button output is active-high. It is meant to drive an external open-drain transistor that pulls the button line low, so the host's button net is never driven high. All timing comes from a clock divider that makes a millisecond tick. The divider ratio, the wait length, the press length and the filter depth are all parameters.

Top module: `pwron_seq`

## Requirements
- R1: While reset is asserted, on every rising clock edge the state returns to WAIT and the button output goes low. After reset is released, the loop begins with a fresh WAIT.
- R2: Each WAIT lasts exactly WAIT_MS × CLKS_PER_MS clock cycles and then moves to CHECK.
- R3: CHECK lasts exactly one cycle. It moves to DONE if the filtered status is 1 and to PRESS if the filtered status is 0.
- R4: PRESS lasts exactly PRESS_MS × CLKS_PER_MS cycles with the button output high. It then returns to WAIT with the button output low, and the loop repeats without limit.
- R5: The button output is high only in PRESS and never in any other state.
- R6: DONE holds, with the button output low, until the next reset, whatever the status input does.
- R7: The status input passes through two synchronizer flops. A new level is accepted only after the synchronized value has differed from the accepted one on 4 consecutive clock samples. Shorter pulses never change the decision.
- R8: The state output encodes WAIT as 2'b00, CHECK as 2'b01, PRESS as 2'b10 and DONE as 2'b11.
- R9: CHECK decides on the filtered status held during the CHECK cycle. If acceptance completes on the clock edge that ends CHECK, that pass still presses, and the new level takes effect at the next CHECK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sys_on_i | input | 1 | Asynchronous "host is running" status, 1 means on |
| btn_o | output | 1 | Button press request, active high, drives an external open-drain pull-down |
| state_o | output | 2 | Current sequencer state (encoding in R8) |

## Verification
The status filter completing its acceptance and the sequencer taking its one-cycle decision can coincide on the same clock edge. The bench provokes this by raising the status input at a computed cycle, so that acceptance lands exactly on the edge that ends CHECK. It expects one more press before DONE. A second run raises the status one cycle earlier and expects DONE straight away. Status pulses kept one sample short of the acceptance length are applied across a whole wait to show that they never stop a press.

// File: rtl/pwron_pkg.sv
package pwron_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'b00,
        ST_CHECK = 2'b01,
        ST_PRESS = 2'b10,
        ST_DONE  = 2'b11
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e st;
        logic       btn;
    } seq_regs_t;

endpackage

// File: rtl/pwron_tick.sv
// Millisecond tick divider; clr restarts the interval so a state begins on a full tick.
module pwron_tick #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int DW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLKS_PER_MS - 1);

    logic [DW-1:0] div_d, div_q;

    always_comb begin
        tick_o = (div_q == DIV_LAST);
        if (clr_i || tick_o) begin
            div_d = '0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/pwron_mscount.sv
// Counts elapsed ticks since the last clear, saturating at MAX_MS-1.
module pwron_mscount #(
    parameter int MAX_MS = 3000,
    localparam int CW = (MAX_MS > 1) ? $clog2(MAX_MS) : 1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clr_i,
    input  logic          tick_i,
    output logic [CW-1:0] ms_o
);
    localparam logic [CW-1:0] CNT_LAST = CW'(MAX_MS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != CNT_LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ms_o = cnt_q;
endmodule

// File: rtl/pwron_debounce.sv
// Synchronizer chain followed by an agreement counter on the synchronized level.
module pwron_debounce #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_LEN     = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic level_o
);
    localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
    localparam logic [CW-1:0] AGREE_LAST = CW'(DEB_LEN - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   stable;
    } deb_regs_t;

    deb_regs_t r_d, r_q;
    logic      sample;

    always_comb begin
        r_d    = r_q;
        r_d.sync = {r_q.sync[SYNC_STAGES-2:0], async_i};
        sample = r_q.sync[SYNC_STAGES-1];
        if (sample != r_q.stable) begin
            if (r_q.cnt == AGREE_LAST) begin
                r_d.stable = sample;
                r_d.cnt    = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign level_o = r_q.stable;
endmodule

// File: rtl/pwron_seq.sv
module pwron_seq #(
    parameter int CLKS_PER_MS = 50000,
    parameter int WAIT_MS     = 3000,
    parameter int PRESS_MS    = 500,
    parameter int DEB_LEN     = 4
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       sys_on_i,
    output logic       btn_o,
    output logic [1:0] state_o
);
    import pwron_pkg::*;

    localparam int MAX_MS = (WAIT_MS > PRESS_MS) ? WAIT_MS : PRESS_MS;
    localparam int CW     = (MAX_MS > 1) ? $clog2(MAX_MS) : 1;
    localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_MS - 1);
    localparam logic [CW-1:0] PRESS_LAST = CW'(PRESS_MS - 1);

    seq_regs_t     s_d, s_q;
    logic          tick;
    logic          clr;
    logic          host_on;
    logic [CW-1:0] ms_cnt;

    pwron_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (clr),
        .tick_o (tick)
    );

    pwron_mscount #(.MAX_MS(MAX_MS)) u_ms (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (clr),
        .tick_i (tick),
        .ms_o   (ms_cnt)
    );

    pwron_debounce #(.SYNC_STAGES(2), .DEB_LEN(DEB_LEN)) u_deb (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (sys_on_i),
        .level_o (host_on)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_WAIT: begin
                if (tick && (ms_cnt == WAIT_LAST)) begin
                    s_d.st = ST_CHECK;
                end
            end
            ST_CHECK: begin
                s_d.st = host_on ? ST_DONE : ST_PRESS;
            end
            ST_PRESS: begin
                if (tick && (ms_cnt == PRESS_LAST)) begin
                    s_d.st = ST_WAIT;
                end
            end
            default: begin
                s_d.st = ST_DONE;
            end
        endcase
        s_d.btn = (s_d.st == ST_PRESS);
        clr     = (s_d.st != s_q.st);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '{st: ST_WAIT, btn: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign btn_o   = s_q.btn;
    assign state_o = s_q.st;
endmodule

// File: rtl/pwron_seq_chk.sv
module pwron_seq_chk #(
    parameter int CLKS_PER_MS = 50000,
    parameter int WAIT_MS     = 3000,
    parameter int PRESS_MS    = 500
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       btn_o,
    input logic [1:0] state_o
);
    localparam int WAIT_CYC  = WAIT_MS * CLKS_PER_MS;
    localparam int PRESS_CYC = PRESS_MS * CLKS_PER_MS;

    int wait_run_q;
    int press_run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wait_run_q  <= 0;
            press_run_q <= 0;
        end else begin
            if (state_o == 2'b00) begin
                wait_run_q <= wait_run_q + 1;
            end else if (state_o != 2'b01) begin
                wait_run_q <= 0;
            end
            if (state_o == 2'b10) begin
                press_run_q <= press_run_q + 1;
            end else if (state_o == 2'b01) begin
                press_run_q <= 0;
            end
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (state_o == 2'b00 && !btn_o));

    a_r2_wait_length: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'b01) |-> (wait_run_q == WAIT_CYC));

    a_r3_check_single: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'b01) |=> (state_o == 2'b10 || state_o == 2'b11));

    a_r4_press_length: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(state_o) == 2'b10 && state_o != 2'b10) |->
            (state_o == 2'b00 && !btn_o && press_run_q == PRESS_CYC));

    a_r5_button_scope: assert property (@(posedge clk_i) disable iff (rst_i)
        btn_o |-> (state_o == 2'b10));

    a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'b11) |=> (state_o == 2'b11 && !btn_o));
endmodule

bind pwron_seq pwron_seq_chk #(
    .CLKS_PER_MS (CLKS_PER_MS),
    .WAIT_MS     (WAIT_MS),
    .PRESS_MS    (PRESS_MS)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .btn_o   (btn_o),
    .state_o (state_o)
);

// File: tb/pwron_seq_test.sv
`timescale 1ns/1ps
module pwron_seq_test;
    localparam int C   = 4;
    localparam int W   = 10;
    localparam int PM  = 5;
    localparam int PW  = W * C;
    localparam int PQ  = PM * C;
    localparam int PER = PW + 1 + PQ;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sys_on = 1'b0;
    logic       btn;
    logic [1:0] st;

    always #10 clk = ~clk;

    pwron_seq #(.CLKS_PER_MS(C), .WAIT_MS(W), .PRESS_MS(PM), .DEB_LEN(4)) uut (
        .clk_i    (clk),
        .rst_i    (rst),
        .sys_on_i (sys_on),
        .btn_o    (btn),
        .state_o  (st)
    );

    typedef struct {
        int         cyc;
        logic [1:0] st;
        logic       btn;
        string      req;
    } exp_t;

    exp_t expq[$];
    int   ecount;
    int   n_chk  = 0;
    int   n_fail = 0;
    logic [2:0] prev = 3'b000;

    always @(posedge clk) begin
        if (rst) ecount <= 0;
        else     ecount <= ecount + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int cyc, input logic [1:0] s, input logic b, input string req);
        exp_t e;
        e.cyc = cyc; e.st = s; e.btn = b; e.req = req;
        expq.push_back(e);
    endtask

    // One unconfirmed pass starting at cycle base (R2, R3, R4, R8 codes)
    task automatic push_pass(input int base, input string req);
        push(base + PW,          2'b01, 1'b0, req);
        push(base + PW + 1,      2'b10, 1'b1, req);
        push(base + PW + 1 + PQ, 2'b00, 1'b0, req);
    endtask

    task automatic wait_cnt(input int k);
        while (ecount != k) @(negedge clk);
    endtask

    task automatic drain(input int k);
        wait_cnt(k);
        check(expq.size() == 0, "R4", "pending expected transitions", expq.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(st == 2'b00, "R1", "state during reset", st, 0);
        check(btn == 1'b0, "R1", "button during reset", btn, 0);
        rst = 1'b0;
    endtask

    // Monitor: pops one expected item per observed change of {state, button}
    always @(negedge clk) begin
        if (rst) begin
            prev = 3'b000;
        end else if ({st, btn} != prev) begin
            prev = {st, btn};
            check(!(btn && st != 2'b10), "R5", "button outside press, state", st, 2);
            if (expq.size() == 0) begin
                check(1'b0, "R6", "unexpected change to state", st, -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(ecount == e.cyc, e.req, "transition cycle", ecount, e.cyc);
                check(st == e.st,      e.req, "state code", st, e.st);
                check(btn == e.btn,    e.req, "button level", btn, e.btn);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Host never comes on: three full retry passes, then reset inside PRESS (R1, R2, R3, R4)
        sys_on = 1'b0;
        do_reset();
        push_pass(0,       "R2");
        push_pass(PER,     "R3");
        push_pass(2 * PER, "R4");
        push(3 * PER + PW,     2'b01, 1'b0, "R2");
        push(3 * PER + PW + 1, 2'b10, 1'b1, "R4");
        drain(3 * PER + PW + 6);
        check(btn == 1'b1, "R4", "button mid press", btn, 1);
        do_reset();
        check(st == 2'b00 && btn == 1'b0, "R1", "state after reset release", st, 0);

        // Host on from the start: DONE at first CHECK, then lockout while the host turns off (R3, R6)
        sys_on = 1'b1;
        do_reset();
        push(PW,     2'b01, 1'b0, "R3");
        push(PW + 1, 2'b11, 1'b0, "R3");
        wait_cnt(PW + 20);
        sys_on = 1'b0;
        drain(PW + 20 + 3 * PER);
        check(st == 2'b11, "R6", "state after host shutdown", st, 3);
        check(btn == 1'b0, "R6", "button after host shutdown", btn, 0);

        // Status pulses of 3 samples never accepted; steady level accepted next pass (R7)
        sys_on = 1'b0;
        do_reset();
        push_pass(0, "R7");
        push(PER + PW,     2'b01, 1'b0, "R7");
        push(PER + PW + 1, 2'b11, 1'b0, "R7");
        while (ecount < 66) begin
            sys_on = (ecount % 4 != 3);
            @(negedge clk);
        end
        sys_on = 1'b1;
        drain(PER + PW + 30);

        // Acceptance lands on the edge that ends CHECK: one more press first (R9)
        sys_on = 1'b0;
        do_reset();
        push_pass(0, "R9");
        push(PER + PW,     2'b01, 1'b0, "R9");
        push(PER + PW + 1, 2'b11, 1'b0, "R9");
        wait_cnt(PW - 5);
        sys_on = 1'b1;
        drain(PER + PW + 30);

        // Acceptance one cycle earlier: DONE at the first CHECK (R9)
        sys_on = 1'b0;
        do_reset();
        push(PW,     2'b01, 1'b0, "R9");
        push(PW + 1, 2'b11, 1'b0, "R9");
        wait_cnt(PW - 6);
        sys_on = 1'b1;
        drain(PW + 40);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule